// File: doc/BRIEF.md
# Cache range maintenance walker

This block runs cache maintenance for a cache controller whose tag and data arrays sit elsewhere. A requester sends it commands. A range operation is armed by a command that records a start address. A second command of the same range type then supplies the end address. That second command starts a walk. The walk issues one per-line maintenance request for every cache line whose first byte lies between the two addresses, with both ends included. Each request goes out through a valid/acknowledge port that the array side drives.

While the walk runs, a stall output stays high so that the requester holds off. The block also accepts single-line clean, invalidate and clean+invalidate commands, and an invalidate-all command that steps through every set index. A range whose two addresses lie in different 4 KiB pages is refused: the block pulses an error and issues nothing.

Top module: `cache_range_walker`

## Requirements
- R1: After reset, `stall`, `err` and `req_valid` are all low.
- R2: A range start command followed by a range end command of the same type issues requests in ascending order, one line (32 bytes) apart. The first request is the start address rounded up to a multiple of 32. The last is the end address rounded down to a multiple of 32. Range clean uses `cmd_op` 4 (start) and 5 (end) and issues `req_kind` 0. Range invalidate uses `cmd_op` 6 (start) and 7 (end) and issues `req_kind` 1.
- R3: `stall` rises at the clock edge that accepts the end command. It falls at the same edge as the acknowledge handshake of the last line, and it stays high at every edge in between.
- R4: A request keeps `req_valid` high and holds `req_addr` and `req_kind` steady until a cycle in which `req_ack` is high. Only then does the walker move to the next line.
- R5: If the start and end addresses differ in any bit above bit 11, `err` is high for the one cycle after the end command. No request is issued and `stall` stays low.
- R6: An end command is ignored (no request, no stall) in any of these cases:
  - no start command came before it;
  - another command was accepted after the start command;
  - it belongs to the other range type.
- R7: If the rounded-down end address is below the rounded-up start address, no request is issued. `stall` is high for exactly one cycle.
- R8: The single-line commands each issue one request at `cmd_addr` rounded down to a multiple of 32:
  - `cmd_op` 1 issues `req_kind` 0 (clean);
  - `cmd_op` 2 issues `req_kind` 1 (invalidate);
  - `cmd_op` 3 issues `req_kind` 2 (clean+invalidate).
- R9: `cmd_op` 0 (invalidate all) issues SETS requests of `req_kind` 3. Their `req_addr` values are the set indices 0 to SETS-1, in ascending order.
- R10: A command presented while `stall` is high is ignored and produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | ADDR_W | Command byte address |
| stall | output | 1 | Requester must wait while high |
| err | output | 1 | One-cycle pulse on a range that crosses a page |
| req_valid | output | 1 | Per-line request pending |
| req_kind | output | 2 | 0 clean, 1 invalidate, 2 clean+invalidate, 3 set invalidate |
| req_addr | output | ADDR_W | Line address, or set index for kind 3 |
| req_ack | input | 1 | Array side takes the pending request |

## Verification
A wrong first or last line, or a wrong step, shows up in the request stream as soon as the walk begins or ends. It appears as an extra, missing or skipped line address. A broken arm state shows one cycle after an end command: either a walk that should not start, or one that fails to start. Stall timing is checked against the handshakes. A stall that drops late or early differs from the last acknowledge by one cycle. The acknowledge delay varies from one range to the next, so an address that moves without an acknowledge is also caught.

// File: rtl/cache_walk_pkg.sv
package cache_walk_pkg;
  typedef enum logic [2:0] {
    OP_INV_ALL    = 3'd0,
    OP_CLEAN_LINE = 3'd1,
    OP_INV_LINE   = 3'd2,
    OP_CLINV_LINE = 3'd3,
    OP_CLEAN_FROM = 3'd4,
    OP_CLEAN_TO   = 3'd5,
    OP_INV_FROM   = 3'd6,
    OP_INV_TO     = 3'd7
  } maint_op_e;

  typedef enum logic [1:0] {
    K_CLEAN   = 2'd0,
    K_INV     = 2'd1,
    K_CLINV   = 2'd2,
    K_SET_INV = 2'd3
  } line_kind_e;
endpackage

// File: rtl/range_arm.sv
module range_arm #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 5,
  parameter int PAGE_BITS = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          accept,
  input  cache_walk_pkg::maint_op_e     op,
  input  logic [ADDR_W-1:0]             addr,
  output logic                          fire,
  output cache_walk_pkg::line_kind_e    fire_kind,
  output logic [ADDR_W-1:0]             first,
  output logic [ADDR_W-1:0]             last,
  output logic                          empty,
  output logic                          bad_page
);
  import cache_walk_pkg::*;

  localparam logic [ADDR_W:0] LOW_MASK = (ADDR_W+1)'((1 << LINE_BITS) - 1);

  logic              armed_q;
  logic              arm_inv_q;
  logic [ADDR_W-1:0] start_q;
  logic              is_from;
  logic              is_to;
  logic              to_inv;
  logic [ADDR_W:0]   up_w;
  logic [ADDR_W:0]   first_w;

  assign is_from = (op == OP_CLEAN_FROM) || (op == OP_INV_FROM);
  assign is_to   = (op == OP_CLEAN_TO)   || (op == OP_INV_TO);
  assign to_inv  = (op == OP_INV_TO);

  assign fire      = accept && is_to && armed_q && (arm_inv_q == to_inv);
  assign fire_kind = to_inv ? K_INV : K_CLEAN;

  assign up_w    = {1'b0, start_q} + LOW_MASK;
  assign first_w = up_w & ~LOW_MASK;
  assign first   = first_w[ADDR_W-1:0];
  assign last    = addr & ~LOW_MASK[ADDR_W-1:0];
  assign empty   = first_w > {1'b0, last};
  assign bad_page = start_q[ADDR_W-1:PAGE_BITS] != addr[ADDR_W-1:PAGE_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      arm_inv_q <= 1'b0;
      start_q   <= '0;
    end else if (accept) begin
      if (is_from) begin
        armed_q   <= 1'b1;
        arm_inv_q <= (op == OP_INV_FROM);
        start_q   <= addr;
      end else begin
        armed_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/walk_engine.sv
module walk_engine #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        go,
  input  cache_walk_pkg::line_kind_e  go_kind,
  input  logic [ADDR_W-1:0]           go_first,
  input  logic [ADDR_W-1:0]           go_last,
  input  logic                        go_empty,
  input  logic                        go_err,
  input  logic                        req_ack,
  output logic                        stall,
  output logic                        err,
  output logic                        req_valid,
  output cache_walk_pkg::line_kind_e  req_kind,
  output logic [ADDR_W-1:0]           req_addr
);
  import cache_walk_pkg::*;

  localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(1) << LINE_BITS;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} walk_st_e;

  walk_st_e          st;
  logic [ADDR_W-1:0] last_q;
  logic [ADDR_W-1:0] step;

  assign step = (req_kind == K_SET_INV) ? ADDR_W'(1) : LINE_STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      stall     <= 1'b0;
      err       <= 1'b0;
      req_valid <= 1'b0;
      req_kind  <= K_CLEAN;
      req_addr  <= '0;
      last_q    <= '0;
    end else begin
      err <= 1'b0;
      case (st)
        S_IDLE: begin
          if (go) begin
            if (go_err) begin
              err <= 1'b1;
            end else if (go_empty) begin
              stall <= 1'b1;
              st    <= S_HOLD;
            end else begin
              stall     <= 1'b1;
              req_valid <= 1'b1;
              req_addr  <= go_first;
              last_q    <= go_last;
              req_kind  <= go_kind;
              st        <= S_RUN;
            end
          end
        end
        S_HOLD: begin
          stall <= 1'b0;
          st    <= S_IDLE;
        end
        S_RUN: begin
          if (req_ack) begin
            if (req_addr == last_q) begin
              req_valid <= 1'b0;
              stall     <= 1'b0;
              st        <= S_IDLE;
            end else begin
              req_addr <= req_addr + step;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  req_in_stall_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> stall);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_addr) && $stable(req_kind)));

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!stall && !req_valid));

  // R7
  empty_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && !req_valid) |=> !stall);

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ack) |=> (!req_valid || (req_addr == $past(req_addr) + $past(step))));

  // R8
  aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind != K_SET_INV) |-> (req_addr[LINE_BITS-1:0] == '0));
endmodule

// File: rtl/cache_range_walker.sv
module cache_range_walker #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 5,
  parameter int PAGE_BITS = 12,
  parameter int SETS      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              stall,
  output logic              err,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              req_ack
);
  import cache_walk_pkg::*;

  localparam logic [ADDR_W-1:0] LAST_SET = ADDR_W'(SETS - 1);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'((1 << LINE_BITS) - 1);

  maint_op_e         op;
  logic              accept;
  logic              r_fire;
  line_kind_e        r_kind;
  logic [ADDR_W-1:0] r_first;
  logic [ADDR_W-1:0] r_last;
  logic              r_empty;
  logic              r_bad;

  logic              go;
  line_kind_e        go_kind;
  logic [ADDR_W-1:0] go_first;
  logic [ADDR_W-1:0] go_last;
  logic              go_empty;
  logic              go_err;
  line_kind_e        kind_out;

  assign op     = maint_op_e'(cmd_op);
  assign accept = cmd_valid && !stall;

  range_arm #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS), .PAGE_BITS(PAGE_BITS)) u_arm (
    .clk(clk), .rst(rst), .accept(accept), .op(op), .addr(cmd_addr),
    .fire(r_fire), .fire_kind(r_kind), .first(r_first), .last(r_last),
    .empty(r_empty), .bad_page(r_bad)
  );

  always_comb begin
    go       = 1'b0;
    go_kind  = K_CLEAN;
    go_first = cmd_addr & ~LINE_MASK;
    go_last  = cmd_addr & ~LINE_MASK;
    go_empty = 1'b0;
    go_err   = 1'b0;
    case (op)
      OP_INV_ALL: begin
        go       = accept;
        go_kind  = K_SET_INV;
        go_first = '0;
        go_last  = LAST_SET;
      end
      OP_CLEAN_LINE: begin go = accept; go_kind = K_CLEAN; end
      OP_INV_LINE:   begin go = accept; go_kind = K_INV;   end
      OP_CLINV_LINE: begin go = accept; go_kind = K_CLINV; end
      OP_CLEAN_TO, OP_INV_TO: begin
        go       = r_fire;
        go_kind  = r_kind;
        go_first = r_first;
        go_last  = r_last;
        go_empty = r_empty;
        go_err   = r_bad;
      end
      default: go = 1'b0;
    endcase
  end

  walk_engine #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) u_eng (
    .clk(clk), .rst(rst), .go(go), .go_kind(go_kind), .go_first(go_first),
    .go_last(go_last), .go_empty(go_empty), .go_err(go_err), .req_ack(req_ack),
    .stall(stall), .err(err), .req_valid(req_valid), .req_kind(kind_out),
    .req_addr(req_addr)
  );

  assign req_kind = kind_out;

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && !req_valid) |=> !req_valid);
endmodule

// File: tb/sim_cache_range_walker.sv
module sim_cache_range_walker;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 16;
  localparam int NV = 8;
  localparam int unsigned V_S [NV] = '{32'h1000, 32'h2000, 32'h3005, 32'h4FE0,
                                       32'h5000, 32'h6100, 32'h7105, 32'h8FF0};
  localparam int unsigned V_E [NV] = '{32'h1000, 32'h20E0, 32'h3047, 32'h4FFF,
                                       32'h5FFF, 32'h6040, 32'h7110, 32'h9010};
  localparam int V_INV [NV] = '{0, 0, 0, 0, 1, 1, 1, 1};
  localparam int V_N   [NV] = '{1, 8, 2, 1, 128, 0, 0, 0};
  localparam int V_ERR [NV] = '{0, 0, 0, 0, 0, 0, 0, 1};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [31:0] cmd_addr = '0;
  logic        stall, err, req_valid, req_ack;
  logic [1:0]  req_kind;
  logic [31:0] req_addr;

  int checks = 0;
  int fails = 0;
  int ack_delay = 0;
  int ack_cnt = 0;
  int log_n = 0;
  int unsigned log_addr [0:255];
  int log_kind [0:255];
  bit hold_prev = 0;
  logic [31:0] prev_addr;
  logic [1:0] prev_kind;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_range_walker #(.ADDR_W(32), .LINE_BITS(5), .PAGE_BITS(12), .SETS(SETS)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .stall(stall), .err(err), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_ack(req_ack)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial req_ack = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      req_ack = 1'b0; ack_cnt = 0; hold_prev = 0;
    end else begin
      if (hold_prev)
        chk(req_valid && req_addr == prev_addr && req_kind == prev_kind,
            "R4", "request held without ack", longint'(req_addr), longint'(prev_addr));
      if (req_valid) begin
        if (ack_cnt >= ack_delay) begin
          req_ack = 1'b1;
          if (log_n < 256) begin
            log_addr[log_n] = req_addr;
            log_kind[log_n] = int'(req_kind);
          end
          log_n++;
          ack_cnt = 0;
          hold_prev = 0;
        end else begin
          req_ack = 1'b0;
          ack_cnt++;
          hold_prev = 1;
          prev_addr = req_addr;
          prev_kind = req_kind;
        end
      end else begin
        req_ack = 1'b0; ack_cnt = 0; hold_prev = 0;
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [2:0] op, input logic [31:0] a);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle(output int cyc, output bit last_ack);
    bit pa = 0;
    cyc = 0;
    while (stall && cyc < 5000) begin
      pa = req_ack;
      tick();
      cyc++;
    end
    last_ack = pa;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL R3 watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    bit la;
    int bad;
    bit st0, er0;
    int unsigned first;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk(!stall && !err && !req_valid, "R1", "outputs after reset",
        {stall, err, req_valid}, 0);

    // vector table: R2 R3 R5 R7
    for (int i = 0; i < NV; i++) begin
      ack_delay = i % 3;
      log_n = 0;
      send(V_INV[i] != 0 ? 3'd6 : 3'd4, V_S[i]);
      send(V_INV[i] != 0 ? 3'd7 : 3'd5, V_E[i]);
      er0 = err; st0 = stall;
      wait_idle(cyc, la);
      if (V_ERR[i] != 0) begin
        chk(er0, "R5", "err pulse on page cross", er0, 1);
        chk(!st0 && log_n == 0, "R5", "no stall or request on page cross", log_n, 0);
      end else begin
        chk(!er0, "R5", "no err inside one page", er0, 0);
        if (V_N[i] == 0) begin
          chk(st0 && cyc == 1, "R7", "empty range stall cycles", cyc, 1);
          chk(log_n == 0, "R7", "empty range requests", log_n, 0);
        end else begin
          first = (V_S[i] + 31) & ~32'd31;
          chk(st0, "R3", "stall after end write", st0, 1);
          chk(la, "R3", "stall drops at last handshake", la, 1);
          chk(log_n == V_N[i], "R2", "line count", log_n, V_N[i]);
          bad = 0;
          for (int k = 0; k < V_N[i] && k < 256; k++) begin
            if (log_addr[k] != first + 32 * k || log_kind[k] != V_INV[i]) bad++;
          end
          chk(bad == 0, "R2", "line addresses and kind", bad, 0);
        end
      end
    end

    // R8 single-line commands
    ack_delay = 1;
    log_n = 0; send(3'd1, 32'hABCD); wait_idle(cyc, la);
    chk(log_n == 1 && log_addr[0] == 32'hABC0 && log_kind[0] == 0, "R8", "clean line",
        log_addr[0], 32'hABC0);
    log_n = 0; send(3'd2, 32'h0040); wait_idle(cyc, la);
    chk(log_n == 1 && log_addr[0] == 32'h0040 && log_kind[0] == 1, "R8", "invalidate line",
        log_kind[0], 1);
    log_n = 0; send(3'd3, 32'h123F); wait_idle(cyc, la);
    chk(log_n == 1 && log_addr[0] == 32'h1220 && log_kind[0] == 2, "R8", "clean+inv line",
        log_addr[0], 32'h1220);

    // R9 invalidate all
    ack_delay = 0;
    log_n = 0; send(3'd0, 32'hFFFF_FFFF); wait_idle(cyc, la);
    chk(log_n == SETS, "R9", "set count", log_n, SETS);
    bad = 0;
    for (int k = 0; k < SETS; k++)
      if (log_addr[k] != k || log_kind[k] != 3) bad++;
    chk(bad == 0, "R9", "set indices", bad, 0);

    // R6 ignored end writes
    log_n = 0; send(3'd5, 32'h0100);
    chk(!stall, "R6", "end with no start", stall, 0);
    repeat (3) tick();
    chk(log_n == 0, "R6", "no request from lone end", log_n, 0);
    send(3'd4, 32'h0200); send(3'd1, 32'h0300); wait_idle(cyc, la);
    log_n = 0; send(3'd5, 32'h0240);
    chk(!stall && log_n == 0, "R6", "end after intervening command", stall, 0);
    send(3'd6, 32'h0200); send(3'd5, 32'h0240);
    chk(!stall, "R6", "end of other type", stall, 0);
    send(3'd7, 32'h0240);
    repeat (3) tick();
    chk(!stall && log_n == 0, "R6", "disarmed after mismatch", log_n, 0);

    // R10 command during walk
    ack_delay = 2;
    log_n = 0;
    send(3'd4, 32'h1000); send(3'd5, 32'h10E0);
    tick();
    send(3'd1, 32'h7770);
    wait_idle(cyc, la);
    repeat (4) tick();
    chk(log_n == 8 && !stall, "R10", "command during stall ignored", log_n, 8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule